// File: doc/BRIEF.md
# Serial Register-Access Slave

This block gives an external host read and write access to a bank of byte-wide control registers over a four-wire SPI link with clock polarity 0 and clock phase 1. The host lowers the select line and sends a command byte, MSB first. The upper seven bits of that byte are the register address, and bit 0 selects the direction: 0 writes and 1 reads. A write sends one data byte, which is stored after its last bit. A read returns the addressed register on MISO during the next eight SCLK periods. After those sixteen bits, further clocks are ignored until the select line rises and falls again.

The three link inputs pass through two-flop synchronizers into the system clock domain. SCLK edges are found there by oversampling. A mode strap is captured once, in the first system clock after reset is released, and the link only responds if the strap reads high. The register contents reset to a computed default image and are presented in parallel on `regs_o` for the rest of the chip.

The frame controller has five states:
- `ST_IDLE`: no frame is in progress.
- `ST_CMD`: the command byte is being shifted in.
- `ST_WR`: the data byte of a write is being shifted in.
- `ST_RD`: the register byte of a read is being shifted out.
- `ST_HOLD`: the frame is complete and later bits are ignored.

The controller moves between these states as follows:
- IDLE to CMD on a select falling edge while the link is enabled.
- CMD to WR or CMD to RD at the eighth SCLK falling edge, chosen by the received direction bit.
- WR to HOLD and RD to HOLD at the sixteenth falling edge.
- Any non-IDLE state to IDLE whenever select is high. If a write is still in progress, this abandons it.

Top module: `spi_regbank_slave`

## Requirements
- R1: The strap level is sampled in the first clock after reset release. If it was low, no register changes and `miso_oe_o` stays 0 until the next reset. Later strap changes have no effect.
- R2: The first byte after a select falling edge is the command. Bits 7:1 hold the address (0 to 127) and bit 0 the direction (1 = read, 0 = write). Every address, including 0 and 127, is reachable.
- R3: In a write, the second byte (MSB first) is stored into the addressed register after its eighth bit, and it then appears on that register's slice `regs_o[8*a +: 8]`.
- R4: In a read, MISO carries the addressed register MSB first, changing after each SCLK rising edge of bits 9 to 16, with `miso_oe_o` high over that span.
- R5: Bits clocked after the sixteenth bit while select stays low cause no write, even if they form a valid command.
- R6: If select rises before the sixteenth bit of a write, no register changes.
- R7: After reset, register i holds (90 + 29*i) mod 256.
- R8: `miso_oe_o` is 0 and `miso_o` is 0 while select is high, during the command byte, and after the data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCLK rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_spi_i | input | 1 | Mode strap, high enables the link |
| ss_n_i | input | 1 | Active-low frame select from the host |
| sclk_i | input | 1 | Serial clock from the host, idles low |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| miso_oe_o | output | 1 | Output enable for the MISO pad |
| regs_o | output | 1024 | All registers, register i at bits 8*i+7 to 8*i |

## Verification
The checker watches, on every cycle, the following:
- that the register bank moves only on a write strobe;
- that the strobe fires at most once per select-low window;
- that a disabled link never drives or writes;
- that MISO is quiet whenever its enable is low or select has been high for three cycles;
- that the captured strap never changes.

The bench's scenarios are needed for the rest:
- the bit ordering of commands and data;
- reaching the boundary addresses;
- the exact bit sequence on MISO;
- aborted and overlong frames;
- the default image.

Each scenario is checked against a behavioural model that is compared with the register outputs on every clock.

// File: rtl/spi_regbank_pkg.sv
package spi_regbank_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WR,
        ST_RD,
        ST_HOLD
    } spi_state_e;

    // Default value generator for register idx: base + idx*step
    function automatic int reset_word(input int idx, input int base, input int step);
        return base + idx * step;
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int          N       = 3,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);

    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RST_VAL[b]}};
            end else begin
                chain_q <= {chain_q[STAGES-2:0], d_i[b]};
            end
        end
        assign q_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/spi_regbank_file.sv
module spi_regbank_file #(
    parameter int ADDR_W   = 7,
    parameter int DATA_W   = 8,
    parameter int RST_BASE = 90,
    parameter int RST_STEP = 29
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en_i,
    input  logic [ADDR_W-1:0]                addr_i,
    input  logic [DATA_W-1:0]                wr_data_i,
    output logic [DATA_W-1:0]                rd_data_o,
    output logic [(1<<ADDR_W)*DATA_W-1:0]    regs_o
);

    localparam int NUM_REGS = 1 << ADDR_W;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic [DATA_W-1:0] val_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= DATA_W'(spi_regbank_pkg::reset_word(i, RST_BASE, RST_STEP));
            end else if (wr_en_i && addr_i == ADDR_W'(i)) begin
                val_q <= wr_data_i;
            end
        end
        assign regs_o[i*DATA_W +: DATA_W] = val_q;
    end

    assign rd_data_o = regs_o[addr_i*DATA_W +: DATA_W];

endmodule

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_en_i,
    input  logic              ss_n_i,
    input  logic              sclk_i,
    input  logic              mosi_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wr_en_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              miso_o,
    output logic              miso_oe_o
);
    import spi_regbank_pkg::*;

    localparam int CMD_W   = ADDR_W + 1;
    localparam int SHIFT_W = (CMD_W > DATA_W) ? CMD_W : DATA_W;
    localparam int CNT_W   = $clog2(SHIFT_W + 1);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    spi_state_e          state_q, state_d;
    logic                ss_prev_q, sclk_prev_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [SHIFT_W-1:0]  sh_q, sh_next;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   tx_q;
    logic                miso_q;
    logic                sclk_rise, sclk_fall, ss_fall;
    logic                cmd_last, data_last;

    assign sclk_rise = sclk_i & ~sclk_prev_q;
    assign sclk_fall = ~sclk_i & sclk_prev_q;
    assign ss_fall   = ss_prev_q & ~ss_n_i;
    assign sh_next   = {sh_q[SHIFT_W-2:0], mosi_i};
    assign cmd_last  = (state_q == ST_CMD) && sclk_fall && (cnt_q == CMD_LAST);
    assign data_last = (state_q == ST_WR || state_q == ST_RD) && sclk_fall && (cnt_q == DATA_LAST);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (state_q != ST_IDLE && ss_n_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (spi_en_i && ss_fall) state_d = ST_CMD;
                ST_CMD:  if (cmd_last)  state_d = sh_next[0] ? ST_RD : ST_WR;
                ST_WR:   if (data_last) state_d = ST_HOLD;
                ST_RD:   if (data_last) state_d = ST_HOLD;
                ST_HOLD: state_d = ST_HOLD;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Shift, count and transmit datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ss_prev_q   <= 1'b1;
            sclk_prev_q <= 1'b0;
            cnt_q       <= '0;
            sh_q        <= '0;
            addr_q      <= '0;
            tx_q        <= '0;
            miso_q      <= 1'b0;
        end else begin
            ss_prev_q   <= ss_n_i;
            sclk_prev_q <= sclk_i;

            if (state_q == ST_IDLE || cmd_last || data_last) begin
                cnt_q <= '0;
            end else if (sclk_fall) begin
                cnt_q <= cnt_q + 1'b1;
            end

            if (sclk_fall) begin
                sh_q <= sh_next;
            end

            if (cmd_last) begin
                addr_q <= sh_next[CMD_W-1:1];
            end

            if (state_d != ST_RD) begin
                miso_q <= 1'b0;
            end else if (state_q == ST_RD && sclk_rise) begin
                if (cnt_q == '0) begin
                    miso_q <= rd_data_i[DATA_W-1];
                    tx_q   <= {rd_data_i[DATA_W-2:0], 1'b0};
                end else begin
                    miso_q <= tx_q[DATA_W-1];
                    tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    // Outputs
    always_comb begin
        addr_o    = addr_q;
        wr_en_o   = data_last && (state_q == ST_WR);
        wr_data_o = sh_next[DATA_W-1:0];
        miso_o    = miso_q;
        miso_oe_o = (state_q == ST_RD);
    end

endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int RST_BASE    = 90,
    parameter int RST_STEP    = 29
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          strap_spi_i,
    input  logic                          ss_n_i,
    input  logic                          sclk_i,
    input  logic                          mosi_i,
    output logic                          miso_o,
    output logic                          miso_oe_o,
    output logic [(1<<ADDR_W)*DATA_W-1:0] regs_o
);

    localparam int NUM_REGS = 1 << ADDR_W;

    logic              spi_en_q, strap_done_q;
    logic              ss_s, sclk_s, mosi_s;
    logic              wr_en;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wr_data, rd_data;

    // Strap capture, once after reset release
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spi_en_q     <= 1'b0;
            strap_done_q <= 1'b0;
        end else if (!strap_done_q) begin
            spi_en_q     <= strap_spi_i;
            strap_done_q <= 1'b1;
        end
    end

    spi_pin_sync #(
        .N       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({ss_n_i, sclk_i, mosi_i}),
        .q_o   ({ss_s, sclk_s, mosi_s})
    );

    spi_frame_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_en_i  (spi_en_q),
        .ss_n_i    (ss_s),
        .sclk_i    (sclk_s),
        .mosi_i    (mosi_s),
        .rd_data_i (rd_data),
        .addr_o    (addr),
        .wr_en_o   (wr_en),
        .wr_data_o (wr_data),
        .miso_o    (miso_o),
        .miso_oe_o (miso_oe_o)
    );

    spi_regbank_file #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .RST_BASE (RST_BASE),
        .RST_STEP (RST_STEP)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .addr_i    (addr),
        .wr_data_i (wr_data),
        .rd_data_o (rd_data),
        .regs_o    (regs_o)
    );

endmodule

// File: rtl/spi_regbank_chk.sv
module spi_regbank_chk #(
    parameter int REGS_W = 1024
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ss_n_i,
    input logic              ss_s,
    input logic              miso_o,
    input logic              miso_oe_o,
    input logic [REGS_W-1:0] regs_o,
    input logic              spi_en_q,
    input logic              strap_done_q,
    input logic              wr_en
);

    logic [1:0] wr_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_cnt_q <= '0;
        end else if (ss_s) begin
            wr_cnt_q <= '0;
        end else if (wr_en && wr_cnt_q != 2'd3) begin
            wr_cnt_q <= wr_cnt_q + 1'b1;
        end
    end

    // R1
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_en_q |-> (!wr_en && !miso_oe_o));

    // R1
    strap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strap_done_q |=> $stable(spi_en_q));

    // R3
    regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_o));

    // R5
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_cnt_q == 2'd0));

    // R8
    miso_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !miso_oe_o |-> !miso_o);

    // R8
    idle_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ss_n_i) && $past(ss_n_i, 2) && $past(ss_n_i, 3)) |-> !miso_oe_o);

endmodule

bind spi_regbank_slave spi_regbank_chk #(
    .REGS_W (NUM_REGS * DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ss_n_i       (ss_n_i),
    .ss_s         (ss_s),
    .miso_o       (miso_o),
    .miso_oe_o    (miso_oe_o),
    .regs_o       (regs_o),
    .spi_en_q     (spi_en_q),
    .strap_done_q (strap_done_q),
    .wr_en        (wr_en)
);

// File: tb/spi_regbank_slave_tb.sv
module spi_regbank_slave_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HP         = 8;      // SCLK half period in system clocks
    localparam int NREG       = 128;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         strap = 1'b1;
    logic         ss_n = 1'b1;
    logic         sclk = 1'b0;
    logic         mosi = 1'b0;
    logic         miso, miso_oe;
    logic [1023:0] regs;

    int           checks = 0;
    int           errors = 0;
    int           cyc = 0;
    bit           done = 1'b0;
    bit           cmp_en = 1'b0;
    logic [7:0]   model [NREG];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_regbank_slave u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_spi_i (strap),
        .ss_n_i      (ss_n),
        .sclk_i      (sclk),
        .mosi_i      (mosi),
        .miso_o      (miso),
        .miso_oe_o   (miso_oe),
        .regs_o      (regs)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] dflt(input int i);
        return 8'((90 + 29 * i) % 256);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NREG; i++) model[i] = dflt(i);
    endtask

    // Reference comparison of the whole bank on every clock
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            bit bad = 1'b0;
            checks++;
            for (int i = 0; i < NREG; i++) begin
                if (!bad && regs[i*8 +: 8] !== model[i]) begin
                    bad = 1'b1;
                    errors++;
                    $display("FAIL R3/R7 reg %0d: actual %0h expected %0h", i, regs[i*8 +: 8], model[i]);
                end
            end
        end
    end

    // Drive one frame of nbits; check MISO/OE at each sample point
    task automatic frame(input logic [7:0] cmd, input logic [7:0] dat,
                         input logic [15:0] extra, input int nbits,
                         input bit exp_rd, input logic [7:0] exp_byte);
        logic [31:0] pat;
        pat  = {cmd, dat, extra};
        cmp_en = 1'b0;
        ss_n = 1'b0;
        wait_clks(HP);
        for (int b = 0; b < nbits; b++) begin
            sclk = 1'b1;
            mosi = pat[31-b];
            wait_clks(HP);
            if (exp_rd && b >= 8 && b < 16) begin
                chk("R4", "miso bit", int'(miso), int'(exp_byte[15-b]));
                chk("R4", "oe in read", int'(miso_oe), 1);
            end else begin
                chk("R8", "oe outside read data", int'(miso_oe), 0);
                chk("R8", "miso outside read data", int'(miso), 0);
            end
            sclk = 1'b0;
            wait_clks(HP);
        end
        ss_n = 1'b1;
        wait_clks(4*HP);
        chk("R8", "oe with select high", int'(miso_oe), 0);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] d, input bit enabled);
        frame({a, 1'b0}, d, 16'h0000, 16, 1'b0, 8'h00);
        if (enabled) model[a] = d;
        cmp_en = 1'b1;
        wait_clks(2);
    endtask

    task automatic do_read(input logic [6:0] a);
        frame({a, 1'b1}, 8'h00, 16'h0000, 16, 1'b1, model[a]);
        cmp_en = 1'b1;
        wait_clks(2);
    endtask

    task automatic do_reset(input bit strap_val);
        cmp_en = 1'b0;
        strap = strap_val;
        rst_n = 1'b0;
        wait_clks(5);
        model_reset();
        rst_n = 1'b1;
        wait_clks(5);
        cmp_en = 1'b1;
    endtask

    initial begin
        model_reset();
        do_reset(1'b1);

        // R7: reset image, R8: outputs quiet
        for (int i = 0; i < NREG; i += 17)
            chk("R7", "reset value", int'(regs[i*8 +: 8]), int'(dflt(i)));
        chk("R7", "reset value top", int'(regs[127*8 +: 8]), int'(dflt(127)));
        chk("R8", "oe after reset", int'(miso_oe), 0);

        // R2/R3/R4: basic write and read-back
        do_write(7'h05, 8'h3C, 1'b1);
        chk("R3", "reg 5 slice", int'(regs[5*8 +: 8]), 8'h3C);
        do_read(7'h05);

        // R2: boundary addresses
        do_write(7'h7F, 8'hC3, 1'b1);
        do_write(7'h00, 8'h81, 1'b1);
        chk("R2", "reg 127", int'(regs[127*8 +: 8]), 8'hC3);
        chk("R2", "reg 0", int'(regs[7:0]), 8'h81);
        do_read(7'h7F);
        do_read(7'h00);

        // R4: read of an untouched register
        do_read(7'h33);

        // R6: select rises after 12 bits of a write
        frame({7'h0A, 1'b0}, 8'hFF, 16'h0000, 12, 1'b0, 8'h00);
        cmp_en = 1'b1;
        wait_clks(2);
        chk("R6", "aborted write reg 10", int'(regs[10*8 +: 8]), int'(dflt(10)));
        do_read(7'h0A);

        // R5: trailing bits form a write to reg 1, must be ignored
        frame({7'h14, 1'b0}, 8'h66, {7'h01, 1'b0, 8'hEE}, 32, 1'b0, 8'h00);
        model[8'h14] = 8'h66;
        cmp_en = 1'b1;
        wait_clks(2);
        chk("R5", "reg 1 untouched", int'(regs[1*8 +: 8]), int'(dflt(1)));
        chk("R3", "reg 20 written", int'(regs[20*8 +: 8]), 8'h66);

        // R5: read frame followed by extra bits
        frame({7'h05, 1'b1}, 8'h00, {7'h02, 1'b0, 8'h77}, 32, 1'b1, model[5]);
        cmp_en = 1'b1;
        wait_clks(2);
        chk("R5", "reg 2 untouched", int'(regs[2*8 +: 8]), int'(dflt(2)));

        // R1: strap low disables the link
        do_reset(1'b0);
        do_write(7'h05, 8'h11, 1'b0);
        chk("R1", "write ignored", int'(regs[5*8 +: 8]), int'(dflt(5)));
        frame({7'h05, 1'b1}, 8'h00, 16'h0000, 16, 1'b0, 8'h00);
        cmp_en = 1'b1;
        strap = 1'b1;
        wait_clks(4);
        do_write(7'h06, 8'h22, 1'b0);
        chk("R1", "late strap ignored", int'(regs[6*8 +: 8]), int'(dflt(6)));

        // R1: strap high, later strap drop does not disable
        do_reset(1'b1);
        strap = 1'b0;
        do_write(7'h40, 8'h5A, 1'b1);
        chk("R1", "enabled after strap drop", int'(regs[64*8 +: 8]), 8'h5A);
        do_read(7'h40);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule